// File: doc/BRIEF.md
# Stalled-Clock Watchdog Pulse Injector

This block watches a generated clock output and rescues it when a rising edge is lost. A fast tick clock samples the monitored output once per tick. The block measures how many ticks lie between successive rising edges. It also counts how many consecutive ticks the output has been low. When that low run grows longer than twice the most recently measured period, the block drives one extra pulse, one tick wide. That pulse goes to the clock input of the flip-flop that makes the output, so the output can rise again.

Until two rising edges have been seen after reset, no period is known. In that case a timeout taken from an input port is used. A saturating counter records how many rescue pulses have been issued. An enable input switches the rescue action off. With the enable low, a stuck output simply stays low.

The monitored output is taken to be already synchronous to the tick clock. A missed edge shows up only as the output staying low for too long.

Top module: `clkstall_guard`

## Requirements
- R1: While reset (rst_ni low) is asserted and on the first tick after it is released, rescue_pulse_o is 0 and rescue_cnt_o is 0. Reset discards any measured period.
- R2: The period is the number of ticks from one sampled rising edge of mon_clk_i (sampled 0 on one tick, 1 on the next) to the next one. It is updated at every rising edge from the second one on, and the timeout becomes twice the latest period.
- R3: Until a period has been measured, the timeout is the value on dflt_timeout_i. This value is assumed to be nonzero.
- R4: Let T be the timeout. If mon_clk_i is sampled low on T+1 consecutive ticks with wd_en_i high, rescue_pulse_o is 1 for the tick after the (T+1)-th low sample.
- R5: Each rescue pulse is exactly one tick wide. The low-run count restarts at the pulse, so an output that stays low gets a new pulse every T+1 ticks.
- R6: A tick with mon_clk_i sampled high clears the low-run count and never produces a pulse on the following tick.
- R7: With wd_en_i low, no pulse is produced. The low-run count keeps growing (saturating). If wd_en_i returns high while the run already exceeds T, a pulse follows on the next tick.
- R8: rescue_cnt_o increments by one on the same tick that each pulse appears. It holds at 2^EVENT_W-1 and further pulses are still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast tick clock that samples the monitored output |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wd_en_i | input | 1 | Enables rescue pulses |
| mon_clk_i | input | 1 | Monitored generated clock output, synchronous to clk_i |
| dflt_timeout_i | input | PERIOD_W+1 | Timeout in ticks used before any period is measured |
| rescue_pulse_o | output | 1 | One-tick rescue pulse for the output flip-flop clock |
| rescue_cnt_o | output | EVENT_W | Saturating count of rescue pulses |

## Verification
The bench builds the block with PERIOD_W=6 and EVENT_W=3. With EVENT_W=3, the event counter reaches its ceiling of 7 after a handful of stalls, so saturation can be tested while the output keeps being rescued. Short measured periods of 2, 3 and 8 ticks, together with a default timeout of 4 and later 2, keep every timeout window down to a few ticks. This lets the bench check each one tick by tick, including the switch from the default timeout to a measured one and back after reset.

// File: rtl/clkstall_pkg.sv
package clkstall_pkg;
  // Saturating increment on a 32-bit carrier; callers cast to their width.
  function automatic logic [31:0] sat_next(input logic [31:0] v, input logic [31:0] maxv);
    return (v >= maxv) ? v : v + 32'd1;
  endfunction
endpackage

// File: rtl/rise_period_meter.sv
module rise_period_meter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  output logic [CW-1:0] period_o,
  output logic          period_vld_o
);
  import clkstall_pkg::*;
  localparam logic [CW-1:0] CMAX = '1;

  logic          lvl_q;
  logic          armed_q;
  logic [CW-1:0] run_q;
  logic          rise;

  assign rise = lvl_i & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q        <= 1'b0;
      armed_q      <= 1'b0;
      run_q        <= '0;
      period_o     <= '0;
      period_vld_o <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (rise) begin
        run_q   <= CW'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          period_o     <= run_q;
          period_vld_o <= 1'b1;
        end
      end else begin
        run_q <= CW'(sat_next(32'(run_q), 32'(CMAX)));
      end
    end
  end
endmodule

// File: rtl/low_stall_timer.sv
module low_stall_timer #(
  parameter int TW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  input  logic          en_i,
  input  logic [TW-1:0] limit_i,
  output logic          fire_o,
  output logic          pulse_o
);
  import clkstall_pkg::*;
  localparam logic [TW-1:0] TMAX = '1;

  logic [TW-1:0] low_q;

  assign fire_o = en_i & ~lvl_i & (low_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (lvl_i || fire_o) low_q <= '0;
      else                 low_q <= TW'(sat_next(32'(low_q), 32'(TMAX)));
    end
  end
endmodule

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
  parameter int EW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [EW-1:0] cnt_o
);
  import clkstall_pkg::*;
  localparam logic [EW-1:0] EMAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= EW'(sat_next(32'(cnt_o), 32'(EMAX)));
  end
endmodule

// File: rtl/clkstall_guard.sv
module clkstall_guard #(
  parameter int PERIOD_W = 8,
  parameter int EVENT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wd_en_i,
  input  logic                mon_clk_i,
  input  logic [PERIOD_W:0]   dflt_timeout_i,
  output logic                rescue_pulse_o,
  output logic [EVENT_W-1:0]  rescue_cnt_o
);
  localparam int TW = PERIOD_W + 1;

  logic [PERIOD_W-1:0] period;
  logic                period_vld;
  logic [TW-1:0]       limit;
  logic                fire;

  rise_period_meter #(.CW(PERIOD_W)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvl_i        (mon_clk_i),
    .period_o     (period),
    .period_vld_o (period_vld)
  );

  // Timeout: twice the last period once known, else the default.
  assign limit = period_vld ? {period, 1'b0} : dflt_timeout_i;

  low_stall_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (mon_clk_i),
    .en_i    (wd_en_i),
    .limit_i (limit),
    .fire_o  (fire),
    .pulse_o (rescue_pulse_o)
  );

  sat_event_counter #(.EW(EVENT_W)) u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fire),
    .cnt_o  (rescue_cnt_o)
  );
endmodule

// File: rtl/clkstall_guard_chk.sv
module clkstall_guard_chk #(
  parameter int PERIOD_W = 8,
  parameter int EVENT_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wd_en_i,
  input logic               mon_clk_i,
  input logic [PERIOD_W:0]  dflt_timeout_i,
  input logic               rescue_pulse_o,
  input logic [EVENT_W-1:0] rescue_cnt_o
);
  localparam logic [EVENT_W-1:0] EMAX = '1;

  a_r5_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescue_pulse_o && (dflt_timeout_i != '0) |=> !rescue_pulse_o);

  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !rescue_pulse_o);

  a_r6_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_clk_i |=> !rescue_pulse_o);

  a_r8_holds_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescue_cnt_o == EMAX |=> rescue_cnt_o == EMAX);

  a_r8_steps_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(rescue_cnt_o) |-> rescue_pulse_o);
endmodule

bind clkstall_guard clkstall_guard_chk #(.PERIOD_W(PERIOD_W), .EVENT_W(EVENT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wd_en_i        (wd_en_i),
  .mon_clk_i      (mon_clk_i),
  .dflt_timeout_i (dflt_timeout_i),
  .rescue_pulse_o (rescue_pulse_o),
  .rescue_cnt_o   (rescue_cnt_o)
);

// File: tb/test_clkstall_guard.sv
`timescale 1ns/1ps
module test_clkstall_guard;
  localparam int PW = 6;
  localparam int EW = 3;
  localparam int NV = 34;
  // Vector: {mon, en, expected pulse, expected count[2:0]}, one per tick.
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b010000, 6'b010000, 6'b010000, 6'b010000, 6'b011001,
    6'b010001, 6'b010001, 6'b010001, 6'b010001, 6'b011010,
    6'b110010, 6'b010010, 6'b010010, 6'b110010,
    6'b010010, 6'b010010, 6'b010010, 6'b010010, 6'b010010, 6'b010010,
    6'b011011, 6'b110011, 6'b010011, 6'b110011,
    6'b000011, 6'b000011, 6'b000011, 6'b000011,
    6'b000011, 6'b000011, 6'b000011, 6'b000011,
    6'b011100, 6'b010100
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          mon = 1'b0;
  logic [PW:0]   dflt = 7'd4;
  logic          pulse;
  logic [EW-1:0] cnt;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  clkstall_guard #(.PERIOD_W(PW), .EVENT_W(EW)) i_clkstall_guard (
    .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .mon_clk_i(mon),
    .dflt_timeout_i(dflt), .rescue_pulse_o(pulse), .rescue_cnt_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i < 10) return "R3 default timeout";
    if (i < 21) return "R4 stall vs measured period";
    if (i < 24) return "R2 period update";
    if (i < 33) return "R7 disable";
    return "R5 restart";
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int np;
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", int'(pulse), 0);
    chk("R1 reset count", int'(cnt), 0);
    rst_n = 1'b1;
    // Table walk
    for (int i = 0; i < NV; i++) begin
      mon = VEC[i][5];
      en  = VEC[i][4];
      @(negedge clk);
      chk({tag_of(i), " pulse"}, int'(pulse), int'(VEC[i][3]));
      chk({tag_of(i), " count"}, int'(cnt), int'(VEC[i][2:0]));
    end
    // R5/R8: held low with timeout 4 (2 x period 2): pulse every 5 ticks, count caps at 7
    np = 4;
    for (int k = 1; k <= 20; k++) begin
      mon = 1'b0; en = 1'b1;
      @(negedge clk);
      chk("R5 repeated pulse spacing", int'(pulse), (k % 5 == 4) ? 1 : 0);
      if (k % 5 == 4) np++;
      chk("R8 saturating count", int'(cnt), (np > 7) ? 7 : np);
    end
    // R1/R3: reset drops the period; default 2 applies again
    @(negedge clk);
    rst_n = 1'b0; dflt = 7'd2;
    @(negedge clk);
    chk("R1 count cleared", int'(cnt), 0);
    chk("R1 pulse cleared", int'(pulse), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      mon = 1'b0; en = 1'b1;
      @(negedge clk);
      chk("R3 new default after reset", int'(pulse), (k == 3) ? 1 : 0);
      chk("R3 count after reset", int'(cnt), (k >= 3) ? 1 : 0);
    end
    // R6: output held high never stalls
    for (int k = 1; k <= 10; k++) begin
      mon = 1'b1;
      @(negedge clk);
      chk("R6 high output no pulse", int'(pulse), 0);
    end
    chk("R6 count unchanged", int'(cnt), 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule